// File: doc/BRIEF.md
# Link Pulse Auto-Polarity Corrector

This block works out whether the receive pair of a twisted-pair port is wired with its polarity swapped. It does this by watching link pulses that an upstream stage has already classified. Each pulse event is marked as either a single normal link pulse or a fast link pulse burst, and it also carries a flag that says whether the pulse arrived inverted. When a long enough run of inverted single pulses arrives, or one inverted burst arrives, the block sets its reverse-polarity state. From then on it flips every received data bit before passing it on.

A small control port covers two fields. One is a disable bit that turns automatic detection off. The other is a reverse bit that software can force while detection is off. While detection is automatic, a link-down indication returns the state to normal polarity, so the next link attempt can detect polarity again.

Top module: `lp_polarity_fixer`

## Requirements
- R1: After reset, `reverse_o` = 0, `auto_disable_o` = 0 and `rx_data_out` = 0.
- R2: With detection automatic and `link_up` = 1, the THRESH-th consecutive inverted single pulse (THRESH = 8) sets `reverse_o`. A pulse event is coded `pulse_valid`=1, `pulse_is_flp`=0, `pulse_inverted`=1. `reverse_o` reads 1 one clock after the edge that accepts that pulse.
- R3: An upright single pulse (`pulse_is_flp`=0, `pulse_inverted`=0) resets the inverted-pulse run to zero. So 7 inverted pulses, then one upright pulse, then 7 more inverted pulses leave `reverse_o` at 0.
- R4: With detection automatic and the link up, one inverted burst (`pulse_is_flp`=1, `pulse_inverted`=1) sets `reverse_o` on the next cycle.
- R5: With detection automatic, `link_up` = 0 clears `reverse_o` and the inverted-pulse run on the next cycle.
- R6: `rx_data_out` equals `rx_data_in` XOR the value `reverse_o` held at the edge that captures it. The XOR is applied to every bit, and the output appears one cycle after the input.
- R7: A control write with `ctl_wr_disable`=1 sets `auto_disable_o` and loads `ctl_wr_reverse` into `reverse_o`. While disabled, pulses and link-down leave `reverse_o` unchanged. A later write with `ctl_wr_disable`=0 restores automatic detection.
- R8: A control write with `ctl_wr_disable`=0 ignores `ctl_wr_reverse`.
- R9: An upright burst neither resets nor advances the inverted-pulse run. 4 inverted pulses, an upright burst, then 4 more inverted pulses set `reverse_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_valid | input | 1 | A classified pulse event is present this cycle |
| pulse_is_flp | input | 1 | 1 = fast link pulse burst, 0 = single normal pulse |
| pulse_inverted | input | 1 | 1 = the pulse arrived inverted |
| link_up | input | 1 | Link status from the link integrity logic |
| rx_data_in | input | DATA_W | Raw received data bits |
| ctl_wr_en | input | 1 | Control write strobe |
| ctl_wr_disable | input | 1 | Disable field of the write |
| ctl_wr_reverse | input | 1 | Reverse field of the write |
| auto_disable_o | output | 1 | Current disable bit |
| reverse_o | output | 1 | Current reverse-polarity bit |
| rx_data_out | output | DATA_W | Polarity-corrected data |

## Verification
Each stimulus cycle has fixed latencies. A pulse, link level or control write changes `reverse_o` and `auto_disable_o` after one edge. A data bit comes out corrected one edge later, using the polarity that was in force before that same edge. The driver applies each stimulus at a falling edge and pushes one expected item per cycle. The monitor pops that item 2 ns after the next rising edge, so every comparison lands exactly one register stage after its stimulus.

// File: rtl/pol_pkg.sv
package pol_pkg;
  // Classified pulse event as seen by the detector
  typedef struct packed {
    logic valid;
    logic flp;
    logic inv;
  } pulse_ev_t;

  localparam int unsigned DEF_THRESH = 8;
  localparam int unsigned DEF_DATA_W = 2;
endpackage

// File: rtl/pol_nlp_run.sv
module pol_nlp_run
  import pol_pkg::*;
#(
  parameter int unsigned THRESH = DEF_THRESH
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enable,
  input  pulse_ev_t ev,
  output logic      hit
);
  localparam int unsigned CW = (THRESH > 2) ? $clog2(THRESH) : 1;
  localparam logic [CW-1:0] LAST = CW'(THRESH - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          nlp_inv, nlp_up;

  assign nlp_inv = ev.valid && !ev.flp && ev.inv;
  assign nlp_up  = ev.valid && !ev.flp && !ev.inv;
  assign hit     = enable && nlp_inv && (cnt_q == LAST);

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (!enable) begin
      cnt_d  = '0;
      cnt_en = (cnt_q != '0);
    end else if (hit || nlp_up) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (nlp_inv) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pol_state.sv
module pol_state (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_dis,
  input  logic wr_rev,
  input  logic auto_on,
  input  logic link_up,
  input  logic set_hit,
  output logic dis_q,
  output logic rev_q
);
  logic dis_d, rev_d, st_en;

  always_comb begin
    dis_d = dis_q;
    rev_d = rev_q;
    if (wr_en) dis_d = wr_dis;
    if (wr_en && wr_dis)   rev_d = wr_rev;
    else if (auto_on) begin
      if (!link_up)        rev_d = 1'b0;
      else if (set_hit)    rev_d = 1'b1;
    end
    st_en = (dis_d != dis_q) || (rev_d != rev_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_q <= 1'b0;
      rev_q <= 1'b0;
    end else if (st_en) begin
      dis_q <= dis_d;
      rev_q <= rev_d;
    end
  end
endmodule

// File: rtl/pol_data_xor.sv
module pol_data_xor #(
  parameter int unsigned DATA_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flip,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] d_next;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign d_next[i] = din[i] ^ flip;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout <= '0;
    else        dout <= d_next;
  end
endmodule

// File: rtl/lp_polarity_fixer.sv
module lp_polarity_fixer
  import pol_pkg::*;
#(
  parameter int unsigned THRESH = DEF_THRESH,
  parameter int unsigned DATA_W = DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pulse_valid,
  input  logic              pulse_is_flp,
  input  logic              pulse_inverted,
  input  logic              link_up,
  input  logic [DATA_W-1:0] rx_data_in,
  input  logic              ctl_wr_en,
  input  logic              ctl_wr_disable,
  input  logic              ctl_wr_reverse,
  output logic              auto_disable_o,
  output logic              reverse_o,
  output logic [DATA_W-1:0] rx_data_out
);
  pulse_ev_t ev;
  logic      auto_on, run_en, nlp_hit, flp_hit, dis_q, rev_q;

  assign ev      = '{valid: pulse_valid, flp: pulse_is_flp, inv: pulse_inverted};
  // detection runs when the disable bit (after any write this cycle) is clear
  assign auto_on = ctl_wr_en ? !ctl_wr_disable : !dis_q;
  assign run_en  = auto_on && link_up;
  assign flp_hit = ev.valid && ev.flp && ev.inv;

  pol_nlp_run #(.THRESH(THRESH)) u_run (
    .clk(clk), .rst_n(rst_n), .enable(run_en), .ev(ev), .hit(nlp_hit)
  );

  pol_state u_state (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ctl_wr_en), .wr_dis(ctl_wr_disable), .wr_rev(ctl_wr_reverse),
    .auto_on(auto_on), .link_up(link_up), .set_hit(nlp_hit || flp_hit),
    .dis_q(dis_q), .rev_q(rev_q)
  );

  pol_data_xor #(.DATA_W(DATA_W)) u_xor (
    .clk(clk), .rst_n(rst_n), .flip(rev_q), .din(rx_data_in), .dout(rx_data_out)
  );

  assign auto_disable_o = dis_q;
  assign reverse_o      = rev_q;
endmodule

// File: rtl/lp_polarity_fixer_chk.sv
module lp_polarity_fixer_chk #(
  parameter int unsigned DATA_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pulse_valid,
  input logic              pulse_inverted,
  input logic              link_up,
  input logic [DATA_W-1:0] rx_data_in,
  input logic              ctl_wr_en,
  input logic              ctl_wr_disable,
  input logic              ctl_wr_reverse,
  input logic              auto_disable_o,
  input logic              reverse_o,
  input logic [DATA_W-1:0] rx_data_out
);
  assert_auto_rise_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_wr_en && !auto_disable_o && !reverse_o) |=>
      (!reverse_o || $past(pulse_valid && pulse_inverted && link_up)));

  assert_link_down_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    (!link_up && !auto_disable_o && !ctl_wr_en) |=> !reverse_o);

  assert_data_flip_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rx_data_out == ($past(rx_data_in) ^ {DATA_W{$past(reverse_o)}})));

  assert_force_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr_en && ctl_wr_disable) |=>
      (auto_disable_o && (reverse_o == $past(ctl_wr_reverse))));

  assert_hold_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    (auto_disable_o && !ctl_wr_en) |=> $stable(reverse_o));

  assert_ignore_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr_en && !ctl_wr_disable && !reverse_o && !(pulse_valid && pulse_inverted))
      |=> !reverse_o);
endmodule

bind lp_polarity_fixer lp_polarity_fixer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pulse_valid(pulse_valid),
  .pulse_inverted(pulse_inverted), .link_up(link_up), .rx_data_in(rx_data_in),
  .ctl_wr_en(ctl_wr_en), .ctl_wr_disable(ctl_wr_disable),
  .ctl_wr_reverse(ctl_wr_reverse), .auto_disable_o(auto_disable_o),
  .reverse_o(reverse_o), .rx_data_out(rx_data_out)
);

// File: tb/tb_lp_polarity_fixer.sv
`timescale 1ns/1ps
module tb_lp_polarity_fixer;
  localparam int DW = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic pulse_valid, pulse_is_flp, pulse_inverted, link_up;
  logic [DW-1:0] rx_data_in;
  logic ctl_wr_en, ctl_wr_disable, ctl_wr_reverse;
  logic auto_disable_o, reverse_o;
  logic [DW-1:0] rx_data_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  bit         q_rev[$];
  bit         q_dis[$];
  bit [DW-1:0] q_dat[$];
  string      q_tag[$];

  bit m_rev = 0, m_dis = 0;
  int m_cnt = 0;
  bit [DW-1:0] seed_dat = 2'b01;

  always #4 clk = ~clk;

  lp_polarity_fixer #(.THRESH(8), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .pulse_valid(pulse_valid),
    .pulse_is_flp(pulse_is_flp), .pulse_inverted(pulse_inverted),
    .link_up(link_up), .rx_data_in(rx_data_in), .ctl_wr_en(ctl_wr_en),
    .ctl_wr_disable(ctl_wr_disable), .ctl_wr_reverse(ctl_wr_reverse),
    .auto_disable_o(auto_disable_o), .reverse_o(reverse_o),
    .rx_data_out(rx_data_out)
  );

  task automatic check(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // driver: one stimulus per cycle, expected result pushed into the queue
  task automatic step(bit v, bit flp, bit inv, bit lk, bit wr, bit wd, bit wrv, string tag);
    bit auto_on;
    @(negedge clk);
    seed_dat = seed_dat * 3 + 1;
    pulse_valid = v; pulse_is_flp = flp; pulse_inverted = inv; link_up = lk;
    rx_data_in = seed_dat; ctl_wr_en = wr; ctl_wr_disable = wd; ctl_wr_reverse = wrv;
    q_dat.push_back(seed_dat ^ {DW{m_rev}});  // R6
    auto_on = wr ? !wd : !m_dis;
    if (wr) m_dis = wd;
    if (wr && wd) begin
      m_rev = wrv; m_cnt = 0;
    end else if (!auto_on) m_cnt = 0;
    else if (!lk) begin
      m_rev = 0; m_cnt = 0;
    end else if (v) begin
      if (flp) begin
        if (inv) m_rev = 1;
      end else if (inv) begin
        if (m_cnt == 7) begin m_rev = 1; m_cnt = 0; end
        else m_cnt++;
      end else m_cnt = 0;
    end
    q_rev.push_back(m_rev);
    q_dis.push_back(m_dis);
    q_tag.push_back(tag);
  endtask

  task automatic idle(string tag);
    step(0, 0, 0, 1, 0, 0, 0, tag);
  endtask

  task automatic nlp(bit inv, string tag);
    step(1, 0, inv, 1, 0, 0, 0, tag);
    idle(tag);
  endtask

  // monitor: pops one expected item per clock, 2 ns after the rising edge
  always @(posedge clk) begin
    #2;
    if (q_tag.size() > 0) begin
      string t; bit er, ed; bit [DW-1:0] eo;
      t = q_tag.pop_front(); er = q_rev.pop_front();
      ed = q_dis.pop_front(); eo = q_dat.pop_front();
      check(t, "reverse_o", reverse_o, er);
      check(t, "auto_disable_o", auto_disable_o, ed);
      check("R6", "rx_data_out", rx_data_out, eo);
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; pulse_valid = 0; pulse_is_flp = 0; pulse_inverted = 0;
    link_up = 0; rx_data_in = '1; ctl_wr_en = 0; ctl_wr_disable = 0; ctl_wr_reverse = 0;
    repeat (3) @(negedge clk);
    check("R1", "reverse_o", reverse_o, 0);
    check("R1", "auto_disable_o", auto_disable_o, 0);
    check("R1", "rx_data_out", rx_data_out, 0);
    rst_n = 1;
    idle("R1");
    // R2: eight inverted single pulses
    for (int i = 0; i < 8; i++) nlp(1, "R2");
    // R5: link down clears
    step(0, 0, 0, 0, 0, 0, 0, "R5");
    idle("R5");
    // R3: run broken by an upright pulse
    for (int i = 0; i < 7; i++) nlp(1, "R3");
    nlp(0, "R3");
    for (int i = 0; i < 7; i++) nlp(1, "R3");
    nlp(1, "R2");
    step(0, 0, 0, 0, 0, 0, 0, "R5");
    // R4: single inverted burst
    step(1, 1, 1, 1, 0, 0, 0, "R4");
    idle("R4");
    step(0, 0, 0, 0, 0, 0, 0, "R5");
    // R9: upright burst leaves the run alone
    for (int i = 0; i < 4; i++) nlp(1, "R9");
    step(1, 1, 0, 1, 0, 0, 0, "R9");
    for (int i = 0; i < 4; i++) nlp(1, "R9");
    step(0, 0, 0, 0, 0, 0, 0, "R5");
    // R8: reverse field ignored when not disabling
    step(0, 0, 0, 1, 1, 0, 1, "R8");
    idle("R8");
    // R7: forced control
    step(0, 0, 0, 1, 1, 1, 1, "R7");
    step(0, 0, 0, 0, 0, 0, 0, "R7");
    idle("R7");
    step(0, 0, 0, 1, 1, 1, 0, "R7");
    step(1, 1, 1, 1, 0, 0, 0, "R7");
    for (int i = 0; i < 9; i++) nlp(1, "R7");
    step(0, 0, 0, 1, 1, 0, 0, "R7");
    step(1, 1, 1, 1, 0, 0, 0, "R7");
    idle("R7");
    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule